// File: doc/BRIEF.md
# Dual-Segment Packet Stream Splitter

This block narrows a 256-bit receive packet stream to a 128-bit stream that carries at most one packet segment per beat. Each wide beat is seen as two 128-bit segments, lower (bits 127:0) and upper (bits 255:128). Each segment has its own start and end flag, so one wide beat can close one packet and open the next. The splitter keeps track of whether a packet is open, works out which segments of the beat carry packet data, and forwards only those, lower first. An idle segment is dropped. When both segments are live, the input is held off for one cycle so that both can leave through the narrow port.

On the narrow side a beat has one start flag, one end flag and a one-bit empty count in 64-bit words, with a valid/ready handshake. A parameter selects a second flag mode in which only bit 0 of the start and end fields is used. That bit covers the whole wide beat, and the empty count decides which segment holds the end. A start that arrives while a packet is already open sets a sticky error flag and opens a new packet.

Top module: `seg_split`

## Requirements
- R1: After synchronous reset, out_valid is 0, proto_err is 0, in_ready is 1 and no packet is open.
- R2: A segment is forwarded only if it is live. A segment is live if its start bit is set or if a packet is open when the segment begins. A wide beat with no live segment is accepted with no stall and produces no output beat. A beat whose only live segment is the upper one produces a single output beat taken from bits 255:128.
- R3: The open-packet state carries across wide beats. A packet closes at the segment whose end bit is set (in_eop bit 0 for lower, bit 1 for upper), and a later segment in the same beat is live only if its own start bit (in_sop bit 0 lower, bit 1 upper) is set. out_sop and out_eop copy the start and end bits of the segment being emitted.
- R4: When both segments of an accepted beat are live, in_ready is low for exactly one cycle while the output is free. The lower segment is emitted, then the upper segment. in_ready is also low whenever out_valid is high and out_ready is low.
- R5: While out_valid is high and out_ready is low, out_valid, out_data, out_sop, out_eop and out_empty hold their values.
- R6: out_empty is 0 on any output beat whose out_eop is 0. When the upper segment closes a packet, out_empty is bit 0 of in_empty. When the lower segment closes a packet, out_empty is in_empty minus 2, or 0 if in_empty is below 2.
- R7: A start bit on a segment that begins with a packet already open sets proto_err. The flag stays set until reset, and that segment is emitted with out_sop set as the first segment of a new packet.
- R8: Asserting rst during operation clears proto_err, out_valid and the open-packet state on the next clock edge.
- R9: With MULTI_PKT=0, in_sop bit 0 marks a start in the lower segment and in_sop bit 1 is ignored. in_eop bit 0 marks the end in the lower segment when in_empty is 2 or more, and in the upper segment otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Wide beat present |
| in_ready | output | 1 | Wide beat accepted on this edge when in_valid is high |
| in_data | input | 256 | Wide beat, lower segment in 127:0 |
| in_sop | input | 2 | Per-segment start bits (bit 0 lower, bit 1 upper) |
| in_eop | input | 2 | Per-segment end bits (bit 0 lower, bit 1 upper) |
| in_empty | input | 2 | Unused 64-bit words in the beat when an end bit is set |
| out_valid | output | 1 | Narrow beat present |
| out_ready | input | 1 | Sink takes the narrow beat |
| out_data | output | 128 | Forwarded segment |
| out_sop | output | 1 | Segment opens a packet |
| out_eop | output | 1 | Segment closes a packet |
| out_empty | output | 1 | Unused 64-bit words in the closing segment |
| proto_err | output | 1 | Sticky flag for a start inside an open packet |

## Verification
The checks assume the source obeys stream rules. A beat offered while in_ready is low is held unchanged until accepted, and in_empty carries meaning only on beats that have an end bit. The bench drives each wide beat from a task that holds it until the handshake completes. It changes out_ready only between edges, so the hold and stall properties meet only legal upstream behaviour. The error scenario breaks packet framing on purpose, but it still keeps to the handshake.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [1:0] live;
        logic [1:0] close;
        logic       open_out;
        logic       err;
    } seg_map_t;

endpackage

// File: rtl/seg_flag_norm.sv
module seg_flag_norm #(
    parameter int MULTI_PKT = 1,
    parameter int QW_SEG    = 2,
    parameter int EMP_W     = 2,
    parameter int OEMP_W    = 1
) (
    input  logic [1:0]             sop_i,
    input  logic [1:0]             eop_i,
    input  logic [EMP_W-1:0]       empty_i,
    output logic [1:0]             sop_o,
    output logic [1:0]             eop_o,
    output logic [1:0][OEMP_W-1:0] emp_o
);
    logic lower_has_room;

    assign lower_has_room = (empty_i >= EMP_W'(QW_SEG));

    always_comb begin
        emp_o[1] = empty_i[OEMP_W-1:0];
        emp_o[0] = '0;
        if (lower_has_room) begin
            emp_o[0] = OEMP_W'(empty_i - EMP_W'(QW_SEG));
        end
    end

    generate
        if (MULTI_PKT != 0) begin : g_multi
            assign sop_o = sop_i;
            assign eop_o = eop_i;
        end else begin : g_single
            assign sop_o = {1'b0, sop_i[0]};
            assign eop_o = lower_has_room ? {1'b0, eop_i[0]} : {eop_i[0], 1'b0};
        end
    endgenerate

endmodule

// File: rtl/seg_live_map.sv
module seg_live_map
    import seg_split_pkg::*;
(
    input  logic       open_i,
    input  logic [1:0] sop_i,
    input  logic [1:0] eop_i,
    output seg_map_t   map_o
);
    logic open_mid;

    always_comb begin
        map_o.live[0]  = sop_i[0] | open_i;
        map_o.close[0] = map_o.live[0] & eop_i[0];
        open_mid       = map_o.live[0] & ~eop_i[0];

        map_o.live[1]  = sop_i[1] | open_mid;
        map_o.close[1] = map_o.live[1] & eop_i[1];
        map_o.open_out = map_o.live[1] & ~eop_i[1];

        map_o.err      = (sop_i[0] & open_i) | (sop_i[1] & open_mid);
    end

endmodule

// File: rtl/seg_split.sv
module seg_split
    import seg_split_pkg::*;
#(
    parameter int SEG_W     = 128,
    parameter int MULTI_PKT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2*SEG_W-1:0]   in_data,
    input  logic [1:0]           in_sop,
    input  logic [1:0]           in_eop,
    input  logic [$clog2(2*(SEG_W/64))-1:0] in_empty,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [SEG_W-1:0]     out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic [((SEG_W/64) > 1 ? $clog2(SEG_W/64) : 1)-1:0] out_empty,
    output logic                 proto_err
);
    localparam int BEAT_W = 2 * SEG_W;
    localparam int QW_SEG = SEG_W / 64;
    localparam int EMP_W  = $clog2(2 * QW_SEG);
    localparam int OEMP_W = (QW_SEG > 1) ? $clog2(QW_SEG) : 1;

    typedef struct packed {
        logic              vld;
        logic [SEG_W-1:0]  dat;
        logic              sop;
        logic              eop;
        logic [OEMP_W-1:0] emp;
        phase_e            phase;
        logic              in_pkt;
        logic              err;
    } st_t;

    st_t st_q, st_d;

    logic [1:0]             n_sop;
    logic [1:0]             n_eop;
    logic [1:0][OEMP_W-1:0] n_emp;
    seg_map_t               map;
    logic                   can_load;
    logic                   both_live;
    logic                   pick_hi;

    seg_flag_norm #(
        .MULTI_PKT (MULTI_PKT),
        .QW_SEG    (QW_SEG),
        .EMP_W     (EMP_W),
        .OEMP_W    (OEMP_W)
    ) u_norm (
        .sop_i   (in_sop),
        .eop_i   (in_eop),
        .empty_i (in_empty),
        .sop_o   (n_sop),
        .eop_o   (n_eop),
        .emp_o   (n_emp)
    );

    seg_live_map u_map (
        .open_i (st_q.in_pkt),
        .sop_i  (n_sop),
        .eop_i  (n_eop),
        .map_o  (map)
    );

    assign can_load  = ~st_q.vld | out_ready;
    assign both_live = (map.live == 2'b11);
    assign in_ready  = can_load & ~((st_q.phase == PH_LOW) & both_live);

    always_comb begin
        st_d    = st_q;
        pick_hi = (st_q.phase == PH_HIGH) | (map.live == 2'b10);

        if (can_load) begin
            st_d.vld = 1'b0;
        end

        if (in_valid && can_load) begin
            if (|map.live) begin
                st_d.vld = 1'b1;
                st_d.dat = pick_hi ? in_data[BEAT_W-1:SEG_W] : in_data[SEG_W-1:0];
                st_d.sop = n_sop[pick_hi];
                st_d.eop = map.close[pick_hi];
                st_d.emp = map.close[pick_hi] ? n_emp[pick_hi] : '0;
            end
            if ((st_q.phase == PH_LOW) && both_live) begin
                st_d.phase = PH_HIGH;
            end else begin
                st_d.phase  = PH_LOW;
                st_d.in_pkt = map.open_out;
                st_d.err    = st_q.err | map.err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld    <= 1'b0;
            st_q.dat    <= '0;
            st_q.sop    <= 1'b0;
            st_q.eop    <= 1'b0;
            st_q.emp    <= '0;
            st_q.phase  <= PH_LOW;
            st_q.in_pkt <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;
    assign out_sop   = st_q.sop;
    assign out_eop   = st_q.eop;
    assign out_empty = st_q.emp;
    assign proto_err = st_q.err;

endmodule

// File: rtl/seg_split_chk.sv
module seg_split_chk #(
    parameter int SEG_W  = 128,
    parameter int OEMP_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SEG_W-1:0]  out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic [OEMP_W-1:0] out_empty,
    input logic              proto_err
);

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && !proto_err));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_sop) && $stable(out_eop) && $stable(out_empty)));

    p_stall_full_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> (out_empty == '0));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

bind seg_split seg_split_chk #(
    .SEG_W  (SEG_W),
    .OEMP_W (OEMP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_empty (out_empty),
    .proto_err (proto_err)
);

// File: tb/seg_split_bench.sv
module seg_split_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] in_data = '0;
    logic [1:0]   in_sop = '0;
    logic [1:0]   in_eop = '0;
    logic [1:0]   in_empty = '0;
    logic         out_ready = 1'b1;

    logic         rdy_m, ov_m, os_m, oe_m, om_m, err_m;
    logic [127:0] od_m;
    logic         rdy_s, ov_s, os_s, oe_s, om_s, err_s;
    logic [127:0] od_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_split #(.SEG_W(128), .MULTI_PKT(1)) u_seg_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_m),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(ov_m), .out_ready(out_ready), .out_data(od_m),
        .out_sop(os_m), .out_eop(oe_m), .out_empty(om_m), .proto_err(err_m)
    );

    seg_split #(.SEG_W(128), .MULTI_PKT(0)) u_seg_split_single (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_s),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(ov_s), .out_ready(out_ready), .out_data(od_s),
        .out_sop(os_s), .out_eop(oe_s), .out_empty(om_s), .proto_err(err_s)
    );

    logic         sel_single = 1'b0;
    logic         s_rdy, s_ov, s_os, s_oe, s_om, s_err;
    logic [127:0] s_od;
    assign s_rdy = sel_single ? rdy_s : rdy_m;
    assign s_ov  = sel_single ? ov_s  : ov_m;
    assign s_os  = sel_single ? os_s  : os_m;
    assign s_oe  = sel_single ? oe_s  : oe_m;
    assign s_om  = sel_single ? om_s  : om_m;
    assign s_err = sel_single ? err_s : err_m;
    assign s_od  = sel_single ? od_s  : od_m;

    int n_total = 0;
    int n_bad   = 0;
    int last_stalls;

    logic [127:0] got_d [64];
    logic         got_s [64];
    logic         got_e [64];
    logic         got_m [64];
    int           got_n = 0;

    always begin
        @(negedge clk);
        #1;
        if (!rst && s_ov && out_ready && got_n < 64) begin
            got_d[got_n] = s_od;
            got_s[got_n] = s_os;
            got_e[got_n] = s_oe;
            got_m[got_n] = s_om;
            got_n = got_n + 1;
        end
    end

    function automatic logic [127:0] pat(input int k);
        return {4{32'h5A00_0000 + k}};
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic chk_seg(input int i, input logic [127:0] d, input logic s,
                           input logic e, input logic m, input string req);
        if (i >= got_n) begin
            chk(1'b0, req, $sformatf("count=%0d", got_n), $sformatf("index %0d", i));
        end else begin
            chk(got_d[i] == d && got_s[i] == s && got_e[i] == e && got_m[i] == m, req,
                $sformatf("d=%h s=%0b e=%0b m=%0b", got_d[i], got_s[i], got_e[i], got_m[i]),
                $sformatf("d=%h s=%0b e=%0b m=%0b", d, s, e, m));
        end
    endtask

    task automatic chk_count(input int n, input string req);
        chk(got_n == n, req, $sformatf("segs=%0d", got_n), $sformatf("segs=%0d", n));
    endtask

    task automatic send_beat(input logic [127:0] hi, input logic [127:0] lo,
                             input logic [1:0] s, input logic [1:0] e, input logic [1:0] m);
        int stalls;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {hi, lo};
        in_sop   = s;
        in_eop   = e;
        in_empty = m;
        stalls   = 0;
        forever begin
            #1;
            if (s_rdy) break;
            @(negedge clk);
            stalls++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        last_stalls = stalls;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        got_n = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(!s_ov && !s_err && s_rdy, "R1", $sformatf("v=%0b err=%0b rdy=%0b", s_ov, s_err, s_rdy), "v=0 err=0 rdy=1");
    endtask

    task automatic t_idle_upper();
        got_n = 0;
        send_beat(pat(1), pat(0), 2'b01, 2'b01, 2'd3);
        drain();
        chk_count(1, "R2");
        chk_seg(0, pat(0), 1'b1, 1'b1, 1'b1, "R2");
        got_n = 0;
        send_beat(pat(3), pat(2), 2'b00, 2'b00, 2'd0);
        chk(last_stalls == 0, "R2", $sformatf("stalls=%0d", last_stalls), "stalls=0");
        drain();
        chk_count(0, "R2");
        got_n = 0;
        send_beat(pat(5), pat(4), 2'b10, 2'b10, 2'd1);
        chk(last_stalls == 0, "R2", $sformatf("stalls=%0d", last_stalls), "stalls=0");
        drain();
        chk_count(1, "R2");
        chk_seg(0, pat(5), 1'b1, 1'b1, 1'b1, "R2");
    endtask

    task automatic t_two_packets();
        got_n = 0;
        send_beat(pat(11), pat(10), 2'b11, 2'b11, 2'd0);
        chk(last_stalls == 1, "R4", $sformatf("stalls=%0d", last_stalls), "stalls=1");
        drain();
        chk_count(2, "R4");
        chk_seg(0, pat(10), 1'b1, 1'b1, 1'b0, "R4");
        chk_seg(1, pat(11), 1'b1, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_multi_beat();
        got_n = 0;
        send_beat(pat(31), pat(30), 2'b01, 2'b00, 2'd0);
        send_beat(pat(33), pat(32), 2'b00, 2'b10, 2'd1);
        send_beat(pat(35), pat(34), 2'b01, 2'b00, 2'd0);
        send_beat(pat(37), pat(36), 2'b10, 2'b01, 2'd0);
        send_beat(pat(39), pat(38), 2'b00, 2'b01, 2'd3);
        drain();
        chk_count(9, "R3");
        chk_seg(0, pat(30), 1'b1, 1'b0, 1'b0, "R3");
        chk_seg(1, pat(31), 1'b0, 1'b0, 1'b0, "R3");
        chk_seg(2, pat(32), 1'b0, 1'b0, 1'b0, "R3");
        chk_seg(3, pat(33), 1'b0, 1'b1, 1'b1, "R6");
        chk_seg(4, pat(34), 1'b1, 1'b0, 1'b0, "R3");
        chk_seg(5, pat(35), 1'b0, 1'b0, 1'b0, "R3");
        chk_seg(6, pat(36), 1'b0, 1'b1, 1'b0, "R6");
        chk_seg(7, pat(37), 1'b1, 1'b0, 1'b0, "R3");
        chk_seg(8, pat(38), 1'b0, 1'b1, 1'b1, "R6");
    endtask

    task automatic t_backpressure();
        got_n = 0;
        @(negedge clk);
        out_ready = 1'b0;
        fork
            send_beat(pat(21), pat(20), 2'b11, 2'b11, 2'd0);
        join_none
        repeat (4) @(negedge clk);
        #1;
        chk(s_ov && s_od == pat(20), "R5", $sformatf("v=%0b d=%h", s_ov, s_od), $sformatf("v=1 d=%h", pat(20)));
        chk(!s_rdy, "R4", $sformatf("rdy=%0b", s_rdy), "rdy=0");
        @(negedge clk);
        #1;
        chk(s_ov && s_od == pat(20) && s_os && s_oe, "R5", $sformatf("d=%h", s_od), $sformatf("d=%h", pat(20)));
        @(negedge clk);
        out_ready = 1'b1;
        wait fork;
        drain();
        chk_count(2, "R5");
        chk_seg(0, pat(20), 1'b1, 1'b1, 1'b0, "R5");
        chk_seg(1, pat(21), 1'b1, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_proto_err();
        got_n = 0;
        chk(!s_err, "R7", $sformatf("err=%0b", s_err), "err=0");
        send_beat(pat(41), pat(40), 2'b01, 2'b00, 2'd0);
        send_beat(pat(43), pat(42), 2'b01, 2'b01, 2'd2);
        drain();
        chk(s_err, "R7", $sformatf("err=%0b", s_err), "err=1");
        chk_count(3, "R7");
        chk_seg(2, pat(42), 1'b1, 1'b1, 1'b0, "R7");
        got_n = 0;
        send_beat(pat(45), pat(44), 2'b11, 2'b11, 2'd0);
        drain();
        chk(s_err, "R7", $sformatf("err=%0b", s_err), "err=1 sticky");
        chk_count(2, "R7");
    endtask

    task automatic t_reset_clear();
        do_reset();
        chk(!s_err && !s_ov, "R8", $sformatf("err=%0b v=%0b", s_err, s_ov), "err=0 v=0");
        send_beat(pat(51), pat(50), 2'b00, 2'b01, 2'd3);
        drain();
        chk_count(0, "R8");
    endtask

    task automatic t_single_mode();
        sel_single = 1'b1;
        do_reset();
        send_beat(pat(61), pat(60), 2'b11, 2'b01, 2'd2);
        drain();
        chk_count(1, "R9");
        chk_seg(0, pat(60), 1'b1, 1'b1, 1'b0, "R9");
        chk(!s_err, "R9", $sformatf("err=%0b", s_err), "err=0");
        got_n = 0;
        send_beat(pat(63), pat(62), 2'b01, 2'b01, 2'd1);
        drain();
        chk_count(2, "R9");
        chk_seg(0, pat(62), 1'b1, 1'b0, 1'b0, "R9");
        chk_seg(1, pat(63), 1'b0, 1'b1, 1'b1, "R9");
        sel_single = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_idle_upper();
        t_two_packets();
        t_multi_beat();
        t_backpressure();
        t_proto_err();
        t_reset_clear();
        t_single_mode();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule